// File: doc/BRIEF.md
# Two-Port Signalling Channel Interrupt Unit

This block sits between a processor's 8-bit register bus and the byte-level side of a two-port serial control channel. The channel carries control bytes to and from digital handsets. Each port has a small receive queue, filled by the line side, and a small transmit queue, drained by the line side. The processor reads received bytes and writes bytes to send through one data register per port.

The unit drives a receive interrupt and a transmit interrupt for each port. Each interrupt source has a bit in an enable register. Queue faults and line faults are latched into status registers that clear when read. A line fault reaches the processor only through the transmit interrupt, and only while that port's transmit queue is empty. A per-port loopback switch turns processor writes back into the same port's receive queue, so the processor path can be tested without the line.

Top module: `sigchan_irq`

## Requirements
- R1: Address 0 is port 0's data register and address 1 is port 1's. A write to it queues a byte for that port's line side, which sees the oldest byte on `line_tx_byte` and `line_tx_avail` high until it pulses `line_tx_take`. Each port has its own `irq_rx` and `irq_tx` bit.
- R2: `irq_rx[p]` is high one cycle after port p's receive queue holds at least one byte, provided enable bit p of the mask register is set. It stays high until the queue is empty.
- R3: `irq_tx[p]` is high while port p's transmit queue is empty, provided enable bit 2+p is set.
- R4: The mask register at address 2 holds six enable bits: [1:0] receive, [3:2] transmit and [5:4] line error for ports 0/1. It reads back what was written and resets to 0, which keeps all interrupts low.
- R5: Reading the queue status register (address 3) or the line status register (address 4) returns its contents and clears it.
- R6: An event that arrives in the same cycle as the read of its status register stays latched after the read.
- R7: A line error on `line_err[p]` sets bit p of address 4. With enable bit 4+p set, it raises `irq_tx[p]` only while port p's transmit queue is empty.
- R8: Bit p of the loopback register (address 5) sends writes to data register p into port p's own receive queue. It leaves the transmit queue untouched and ignores `line_rx_put[p]`.
- R9: Each queue holds 4 bytes. A byte pushed into a full queue is dropped. The drop sets receive-overflow bit p (address 3 bit p) or transmit-overflow bit 4+p.
- R10: Reading an empty receive queue returns 0 and sets bit 2+p of address 3. A take on an empty transmit queue sets bit 6+p.
- R11: Each queue delivers bytes in the order they arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | Write access |
| bus_rd | input | 1 | Read access |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid during the read cycle |
| line_rx_put | input | 2 | Per-port strobe pushing a received byte |
| line_rx_byte | input | 16 | Received bytes, port p at [8p+7:8p] |
| line_tx_take | input | 2 | Per-port strobe taking the oldest transmit byte |
| line_tx_byte | output | 16 | Oldest transmit byte per port |
| line_tx_avail | output | 2 | Transmit queue not empty, per port |
| line_err | input | 2 | Per-port line fault pulse |
| irq_rx | output | 2 | Receive interrupts |
| irq_tx | output | 2 | Transmit interrupts, including gated line faults |

## Verification
Some properties are checked on every cycle. A line push into an enabled port raises the receive interrupt. A processor write into a transmit queue drops that port's transmit interrupt. A transmit interrupt raised only by a line fault comes with an empty queue and a latched fault. A status read clears the line fault bits unless a new fault arrives in the same cycle. The bench scenarios cover the rest: byte order through the queues, overflow drops, underflow reads returning 0, the exact status bit contents, and the loopback path together with the ignored line input.

// File: rtl/sigchan_irq.sv
module sigchan_irq #(
  parameter int DW = 8,
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [2:0]      bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [1:0]      line_rx_put,
  input  logic [2*DW-1:0] line_rx_byte,
  input  logic [1:0]      line_tx_take,
  output logic [2*DW-1:0] line_tx_byte,
  output logic [1:0]      line_tx_avail,
  input  logic [1:0]      line_err,
  output logic [1:0]      irq_rx,
  output logic [1:0]      irq_tx
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [5:0]      en_mask;
  logic [7:0]      buf_st;
  logic [1:0]      line_st;
  logic [1:0]      loop_en;
  logic [1:0]      rx_any, tx_empty;
  logic [1:0]      rxo, rxu, txo, txu;
  logic [2*DW-1:0] rx_head;

  wire wr_en = bus_sel && bus_wr;
  wire rd_en = bus_sel && bus_rd;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] v);
    return (v == PW'(DEPTH - 1)) ? '0 : v + 1'b1;
  endfunction

  for (genvar p = 0; p < 2; p++) begin : g_port
    logic [DW-1:0] rq [DEPTH];
    logic [DW-1:0] tq [DEPTH];
    logic [PW-1:0] rwp, rrp, twp, trp;
    logic [CW-1:0] rn, tn;

    wire dwr = wr_en && (bus_addr == 3'(p));
    wire drd = rd_en && (bus_addr == 3'(p));
    wire rx_req = loop_en[p] ? dwr : line_rx_put[p];
    wire [DW-1:0] rx_din = loop_en[p] ? bus_wdata : line_rx_byte[p*DW +: DW];
    wire rx_pop = drd && (rn != '0);
    wire rx_push = rx_req && ((rn != CW'(DEPTH)) || rx_pop);
    wire tx_req = dwr && !loop_en[p];
    wire tx_pop = line_tx_take[p] && (tn != '0);
    wire tx_push = tx_req && ((tn != CW'(DEPTH)) || tx_pop);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rwp <= '0; rrp <= '0; rn <= '0;
        twp <= '0; trp <= '0; tn <= '0;
      end else begin
        if (rx_push) rwp <= nxt(rwp);
        if (rx_pop)  rrp <= nxt(rrp);
        rn <= rn + CW'(rx_push) - CW'(rx_pop);
        if (tx_push) twp <= nxt(twp);
        if (tx_pop)  trp <= nxt(trp);
        tn <= tn + CW'(tx_push) - CW'(tx_pop);
      end
    end

    always_ff @(posedge clk) begin
      if (rx_push) rq[rwp] <= rx_din;
      if (tx_push) tq[twp] <= bus_wdata;
    end

    assign rx_any[p]   = (rn != '0);
    assign tx_empty[p] = (tn == '0);
    assign rx_head[p*DW +: DW]      = rx_any[p] ? rq[rrp] : '0;
    assign line_tx_byte[p*DW +: DW] = tq[trp];
    assign rxo[p] = rx_req && !rx_push;
    assign rxu[p] = drd && !rx_pop;
    assign txo[p] = tx_req && !tx_push;
    assign txu[p] = line_tx_take[p] && !tx_pop;
  end

  wire clr_buf  = rd_en && (bus_addr == 3'd3);
  wire clr_line = rd_en && (bus_addr == 3'd4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_mask <= '0;
      loop_en <= '0;
      buf_st  <= '0;
      line_st <= '0;
    end else begin
      if (wr_en && bus_addr == 3'd2) en_mask <= bus_wdata[5:0];
      if (wr_en && bus_addr == 3'd5) loop_en <= bus_wdata[1:0];
      buf_st  <= (clr_buf ? 8'h00 : buf_st) | {txu, txo, rxu, rxo};
      line_st <= (clr_line ? 2'b00 : line_st) | line_err;
    end
  end

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = rx_head[DW-1:0];
      3'd1:    bus_rdata = rx_head[2*DW-1:DW];
      3'd2:    bus_rdata = DW'(en_mask);
      3'd3:    bus_rdata = DW'(buf_st);
      3'd4:    bus_rdata = DW'(line_st);
      3'd5:    bus_rdata = DW'(loop_en);
      default: bus_rdata = '0;
    endcase
  end

  assign line_tx_avail = ~tx_empty;
  assign irq_rx = en_mask[1:0] & rx_any;
  assign irq_tx = tx_empty & (en_mask[3:2] | (en_mask[5:4] & line_st));
endmodule

// File: rtl/sigchan_irq_chk.sv
module sigchan_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_sel,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [2:0] bus_addr,
  input logic [1:0] line_rx_put,
  input logic [1:0] line_tx_avail,
  input logic [1:0] line_err,
  input logic [1:0] irq_rx,
  input logic [1:0] irq_tx,
  input logic [5:0] en_mask,
  input logic [1:0] line_st,
  input logic [1:0] loop_en
);
  wire mask_wr = bus_sel && bus_wr && bus_addr == 3'd2;
  wire line_rd = bus_sel && bus_rd && bus_addr == 3'd4;

  a_r2_rx_irq_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (line_rx_put[0] && !loop_en[0] && en_mask[0] && !mask_wr) |=> irq_rx[0]);

  a_r3_tx_write_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 3'd1 && !loop_en[1]) |=> !irq_tx[1]);

  a_r7_err_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_tx[0] && !en_mask[2]) |-> (!line_tx_avail[0] && line_st[0]));

  a_r5_line_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (line_rd && !line_err[1]) |=> !line_st[1]);

  a_r6_no_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (line_rd && line_err[0]) |=> line_st[0]);
endmodule

bind sigchan_irq sigchan_irq_chk i_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .line_rx_put(line_rx_put), .line_tx_avail(line_tx_avail),
  .line_err(line_err), .irq_rx(irq_rx), .irq_tx(irq_tx), .en_mask(en_mask),
  .line_st(line_st), .loop_en(loop_en)
);

// File: tb/test_sigchan_irq.sv
module test_sigchan_irq;
  logic clk = 0, rst_n = 0;
  logic sel = 0, wr = 0, rd = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic [1:0] rx_put = 0, tx_take = 0, lerr = 0;
  logic [15:0] rx_byte = 0, tx_byte;
  logic [1:0] tx_avail, irq_rx, irq_tx;

  int nchk = 0, nerr = 0;
  logic [7:0] mrx [2][4];
  logic [7:0] mtx [2][4];
  int mrn [2], mtn [2];
  logic [7:0] mbuf = 0;
  logic [5:0] mmask = 0;
  logic [1:0] mline = 0;

  sigchan_irq i_sigchan_irq (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .line_rx_put(rx_put), .line_rx_byte(rx_byte),
    .line_tx_take(tx_take), .line_tx_byte(tx_byte), .line_tx_avail(tx_avail),
    .line_err(lerr), .irq_rx(irq_rx), .irq_tx(irq_tx));

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void m_rx_push(int p, logic [7:0] b);
    if (mrn[p] == 4) mbuf[p] = 1'b1;
    else begin mrx[p][mrn[p]] = b; mrn[p]++; end
  endfunction

  function automatic logic [7:0] m_rx_pop(int p);
    logic [7:0] b;
    if (mrn[p] == 0) begin mbuf[2+p] = 1'b1; return 8'h00; end
    b = mrx[p][0];
    for (int i = 0; i < 3; i++) mrx[p][i] = mrx[p][i+1];
    mrn[p]--;
    return b;
  endfunction

  function automatic void m_tx_push(int p, logic [7:0] b);
    if (mtn[p] == 4) mbuf[4+p] = 1'b1;
    else begin mtx[p][mtn[p]] = b; mtn[p]++; end
  endfunction

  function automatic void m_tx_pop(int p);
    if (mtn[p] == 0) begin mbuf[6+p] = 1'b1; return; end
    for (int i = 0; i < 3; i++) mtx[p][i] = mtx[p][i+1];
    mtn[p]--;
  endfunction

  function automatic bit exp_rx(int p);
    return mmask[p] && mrn[p] > 0;
  endfunction

  function automatic bit exp_tx(int p);
    return mtn[p] == 0 && (mmask[2+p] || (mmask[4+p] && mline[p]));
  endfunction

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1; rd = 1; addr = a;
    #1 d = rdata;
    @(negedge clk); sel = 0; rd = 0;
  endtask

  task automatic line_push(input int p, input logic [7:0] b);
    @(negedge clk); rx_put[p] = 1; rx_byte[p*8 +: 8] = b;
    @(negedge clk); rx_put = 0;
  endtask

  task automatic line_take(input int p);
    @(negedge clk);
    if (mtn[p] > 0) check(tx_byte[p*8 +: 8] == mtx[p][0], "R1 tx byte", tx_byte[p*8 +: 8], mtx[p][0]);
    tx_take[p] = 1;
    @(negedge clk); tx_take = 0;
  endtask

  task automatic check_irqs(input string tag);
    for (int p = 0; p < 2; p++) begin
      check(irq_rx[p] == exp_rx(p), {tag, " R2 irq_rx"}, irq_rx[p], exp_rx(p));
      check(irq_tx[p] == exp_tx(p), {tag, " R3 irq_tx"}, irq_tx[p], exp_tx(p));
    end
  endtask

  initial begin
    #(20 * 150000);
    nerr++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd7));
    mrn[0] = 0; mrn[1] = 0; mtn[0] = 0; mtn[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(irq_rx == 2'b00 && irq_tx == 2'b00, "R4 reset irqs", {irq_rx, irq_tx}, 0);
    bus_read(3'd2, d); check(d == 8'h00, "R4 mask reset", d, 0);
    bus_read(3'd3, d); check(d == 8'h00, "R5 status reset", d, 0);

    bus_write(3'd2, 8'h0f); mmask = 6'h0f;
    bus_read(3'd2, d); check(d == 8'h0f, "R4 mask readback", d, 8'h0f);
    @(negedge clk); check_irqs("enabled");

    // R9 and R11: overflow of port 0 receive queue, order preserved
    for (int i = 0; i < 5; i++) begin line_push(0, 8'h10 + 8'(i)); m_rx_push(0, 8'h10 + 8'(i)); end
    check_irqs("full");
    for (int i = 0; i < 4; i++) begin
      bus_read(3'd0, d);
      check(d == m_rx_pop(0), "R11 rx order", d, 8'h10 + i);
    end
    // R10: underflow read returns 0
    bus_read(3'd0, d); void'(m_rx_pop(0));
    check(d == 8'h00, "R10 empty read", d, 0);
    bus_read(3'd3, d);
    check(d == mbuf, "R9 R10 status", d, mbuf);
    check(d == 8'h05, "R9 overflow and R10 underflow bits", d, 8'h05);
    mbuf = 0;
    bus_read(3'd3, d); check(d == 8'h00, "R5 cleared", d, 0);

    // R9: transmit overflow on port 1 and take on empty port 0
    for (int i = 0; i < 5; i++) begin bus_write(3'd1, 8'h20 + 8'(i)); m_tx_push(1, 8'h20 + 8'(i)); end
    check_irqs("tx full");
    line_take(0); m_tx_pop(0);
    bus_read(3'd3, d); check(d == 8'h60, "R9 R10 tx status", d, 8'h60); mbuf = 0;
    for (int i = 0; i < 4; i++) begin line_take(1); m_tx_pop(1); end
    check_irqs("tx drained");

    // R7: line error gated by empty transmit queue
    bus_write(3'd2, 8'h10); mmask = 6'h10;
    @(negedge clk); lerr[0] = 1; @(negedge clk); lerr[0] = 0; mline[0] = 1;
    check(irq_tx[0] == 1'b1, "R7 err irq when tx empty", irq_tx[0], 1);
    bus_write(3'd0, 8'h33); m_tx_push(0, 8'h33);
    check(irq_tx[0] == 1'b0, "R7 err hidden while tx busy", irq_tx[0], 0);
    line_take(0); m_tx_pop(0);
    check(irq_tx[0] == 1'b1, "R7 err back when empty", irq_tx[0], 1);
    // R6: event in the same cycle as the read
    @(negedge clk); sel = 1; rd = 1; addr = 3'd4; lerr[1] = 1;
    #1 d = rdata;
    @(negedge clk); sel = 0; rd = 0; lerr[1] = 0;
    check(d == 8'h01, "R5 line status read", d, 1);
    check(irq_tx[0] == 1'b0, "R5 line status cleared", irq_tx[0], 0);
    bus_read(3'd4, d); check(d == 8'h02, "R6 same-cycle event kept", d, 2);
    mline = 0;

    // R8: loopback on port 0
    bus_write(3'd2, 8'h0f); mmask = 6'h0f;
    bus_write(3'd5, 8'h01);
    bus_write(3'd0, 8'h5a); m_rx_push(0, 8'h5a);
    check(tx_avail[0] == 1'b0, "R8 tx untouched", tx_avail[0], 0);
    line_push(0, 8'hee);
    check_irqs("loop");
    bus_read(3'd0, d); check(d == m_rx_pop(0), "R8 looped byte", d, 8'h5a);
    bus_read(3'd0, d); void'(m_rx_pop(0));
    check(d == 8'h00, "R8 line rx ignored", d, 0);
    bus_write(3'd5, 8'h00);
    bus_read(3'd3, d); check(d == mbuf, "R8 status", d, mbuf); mbuf = 0;

    // random traffic
    for (int n = 0; n < 400; n++) begin
      int p, op;
      logic [7:0] b;
      p = int'($urandom % 2); op = int'($urandom % 5); b = 8'($urandom);
      case (op)
        0: begin line_push(p, b); m_rx_push(p, b); end
        1: begin bus_read(3'(p), d); b = m_rx_pop(p); check(d == b, "R11 rx data", d, b); end
        2: begin bus_write(3'(p), b); m_tx_push(p, b); end
        3: begin line_take(p); m_tx_pop(p); end
        default: begin bus_read(3'd3, d); check(d == mbuf, "R9 R10 status", d, mbuf); mbuf = 0; end
      endcase
      check_irqs("random");
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule